// File: doc/BRIEF.md
# Eye Scan Sweep and Readout Engine

This block runs an eye-opening scan. It walks a sampling point over a square grid of phase and voltage offset codes. At each grid point it counts the samples where an offset comparator's decision differs from the primary data decision. A controller collects the counts through a two-byte register window. The controller never writes to the block during the sweep. The act of starting an MSB read is what moves the sweep to the next point. In burst mode the low byte then shows up at the MSB address, so a stream of reads from one address returns every count in turn.

The sweep runs while fast-scan mode is enabled and a start request has set the start bit. Each point accumulates for a number of samples set by a dwell byte. Results come out of a two-stage pipeline, so the first four bytes after a start are placeholders. Once the last stored count has been read, the engine clears its own start bit.

Top module: `eyescan_engine`

## Requirements
- R1: After reset, `start_bit` is 0, both offset codes are 0, and both readout bytes are 0.
- R2: A `start_req` pulse sets `start_bit` and restarts the sweep at point 0 only while `scan_en` is 1. With `scan_en` at 0 the pulse has no effect.
- R3: While the sweep is running, a sample with `smp_vld` high and `prim_bit` different from `offs_bit` adds one to the count of the current point. Only the first (dwell+1)·2^DWELL_SHIFT valid samples of a point are taken. Larger samples are ignored.
- R4: The 16-bit count of a point saturates at 0xFFFF and does not wrap.
- R5: The point index runs from 0 to 4095. The voltage code is index bits [5:0], so voltage steps fastest. The phase code is bits [11:6], so phase advances when voltage wraps from 63 to 0. Once the index passes the last point, both codes read 0.
- R6: An accepted MSB read starts, in the same clock, the step to the next point and a fresh count. A second `rd_msb` before the pair is finished changes nothing.
- R7: In single-byte mode (`burst_mode`=0), `msb_byte` shows bits [15:8] and `lsb_byte` shows bits [7:0] of the window. An `rd_msb` followed by an `rd_lsb` finishes a pair. The window reloads only when a pair finishes. An `rd_lsb` with no MSB read pending is ignored.
- R8: In burst mode (`burst_mode`=1), after an accepted MSB read, `msb_byte` shows window bits [7:0]. The next `rd_msb` finishes the pair. `rd_lsb` is ignored.
- R9: The first two pairs after a start read 0 (four invalid bytes). Pair k, for k ≥ 2, returns the count of point k−2.
- R10: `start_bit` clears when pair number 4098 after the start finishes. After that, reads change nothing.
- R11: While `scan_en` is 0, the block stays cleared: `start_bit` 0, codes 0, window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Fast-scan enable; low aborts and clears |
| start_req | input | 1 | One-cycle request to set the start bit |
| burst_mode | input | 1 | 1 = burst reads from the MSB address, 0 = single-byte reads |
| dwell | input | 8 | Dwell length per point |
| smp_vld | input | 1 | Sample strobe |
| prim_bit | input | 1 | Primary comparator decision |
| offs_bit | input | 1 | Offset comparator decision |
| rd_msb | input | 1 | Read strobe at the MSB address |
| rd_lsb | input | 1 | Read strobe at the LSB address |
| phase_code | output | 6 | Current phase offset code |
| volt_code | output | 6 | Current voltage offset code |
| msb_byte | output | 8 | Data at the MSB address |
| lsb_byte | output | 8 | Data at the LSB address |
| start_bit | output | 1 | Start bit status; high while a sweep is in progress |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Pipeline offset.** The count of a point first appears two pairs after its own read. An engine with the wrong lag returns neighbouring counts or skips the placeholder bytes.
- **Repeated MSB strobe.** A second `rd_msb` with an unfinished pair and a stray `rd_lsb` with no pending MSB read must both be ignored. An engine that accepts either one skips grid points or reloads the window early.
- **Dwell cutoff and saturation.** Mismatch streams longer than the dwell limit must stop counting at the limit. Streams longer than 65535 must stop at 0xFFFF. A faulty engine overshoots or wraps to a small count.
- **End of sweep and abort.** The start bit must stay set through pair 4097 and drop exactly at pair 4098. The phase code must carry at the voltage wrap. Dropping `scan_en` must zero the codes and the window.

// File: rtl/eyescan_pkg.sv
package eyescan_pkg;

  // Width of one stored count; split into two byte lanes in the window.
  localparam int RES_W  = 16;
  localparam int BYTE_W = 8;

  // Number of valid samples a point integrates for a given dwell code.
  function automatic int unsigned dwell_samples(input int unsigned dw,
                                                input int unsigned shift);
    return (dw + 32'd1) << shift;
  endfunction

  // Increment that sticks at the all-ones value.
  function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] v);
    return (v == {RES_W{1'b1}}) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/eyescan_accum.sv
module eyescan_accum #(
  parameter int DWELL_W     = 8,
  parameter int DWELL_SHIFT = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          active,
  input  logic                          smp_vld,
  input  logic                          prim_bit,
  input  logic                          offs_bit,
  input  logic [DWELL_W-1:0]            dwell,
  output logic [eyescan_pkg::RES_W-1:0] err_cnt,
  output logic                          dwell_full
);
  import eyescan_pkg::*;

  localparam int SMP_W = DWELL_W + DWELL_SHIFT + 1;

  logic [SMP_W-1:0] smp_cnt;
  logic [SMP_W-1:0] smp_lim;
  logic             take_smp;

  assign smp_lim    = SMP_W'(dwell_samples(32'(dwell), DWELL_SHIFT));
  assign dwell_full = (smp_cnt >= smp_lim);
  assign take_smp   = active && smp_vld && !dwell_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_cnt <= '0;
      err_cnt <= '0;
    end else if (clear) begin
      smp_cnt <= '0;
      err_cnt <= '0;
    end else if (take_smp) begin
      smp_cnt <= smp_cnt + 1'b1;
      if (prim_bit != offs_bit) err_cnt <= sat_inc(err_cnt);
    end
  end

endmodule

// File: rtl/eyescan_stepper.sv
module eyescan_stepper #(
  parameter int PH_W = 6,
  parameter int VO_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            advance,
  output logic            in_grid,
  output logic [PH_W-1:0] phase_code,
  output logic [VO_W-1:0] volt_code
);
  localparam int IDX_W = PH_W + VO_W;

  // One extra bit marks "past the last point".
  logic [IDX_W:0] pt;

  assign in_grid    = !pt[IDX_W];
  assign volt_code  = pt[VO_W-1:0];
  assign phase_code = pt[IDX_W-1:VO_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pt <= '0;
    else if (clear)               pt <= '0;
    else if (advance && in_grid)  pt <= pt + 1'b1;
  end

endmodule

// File: rtl/eyescan_window.sv
module eyescan_window #(
  parameter int GRID    = 4096,
  parameter int RES_LAG = 2,
  parameter int PC_W    = 13
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           running,
  input  logic                           burst,
  input  logic                           rd_msb,
  input  logic                           rd_lsb,
  input  logic [eyescan_pkg::RES_W-1:0]  capt_val,
  output logic [eyescan_pkg::BYTE_W-1:0] msb_byte,
  output logic [eyescan_pkg::BYTE_W-1:0] lsb_byte,
  output logic                           step_evt,
  output logic                           pair_evt,
  output logic                           last_pair
);
  import eyescan_pkg::*;

  logic [RES_W-1:0] stg [RES_LAG];
  logic [RES_W-1:0] win;
  logic             msb_taken;
  logic [PC_W-1:0]  pair_cnt;

  assign step_evt  = running && !msb_taken && rd_msb;
  assign pair_evt  = running && msb_taken && (burst ? rd_msb : rd_lsb);
  assign last_pair = (pair_cnt == PC_W'(GRID + RES_LAG - 1));

  assign msb_byte  = (burst && msb_taken) ? win[BYTE_W-1:0] : win[RES_W-1:BYTE_W];
  assign lsb_byte  = win[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RES_LAG; i++) stg[i] <= '0;
      win       <= '0;
      msb_taken <= 1'b0;
      pair_cnt  <= '0;
    end else if (clear) begin
      for (int i = 0; i < RES_LAG; i++) stg[i] <= '0;
      win       <= '0;
      msb_taken <= 1'b0;
      pair_cnt  <= '0;
    end else begin
      if (step_evt) begin
        stg[0] <= capt_val;
        for (int i = 1; i < RES_LAG; i++) stg[i] <= stg[i-1];
        msb_taken <= 1'b1;
      end
      if (pair_evt) begin
        win       <= stg[RES_LAG-1];
        msb_taken <= 1'b0;
        pair_cnt  <= pair_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/eyescan_engine.sv
module eyescan_engine #(
  parameter int PH_W        = 6,
  parameter int VO_W        = 6,
  parameter int DWELL_W     = 8,
  parameter int DWELL_SHIFT = 10,
  parameter int RES_LAG     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               start_req,
  input  logic               burst_mode,
  input  logic [DWELL_W-1:0] dwell,
  input  logic               smp_vld,
  input  logic               prim_bit,
  input  logic               offs_bit,
  input  logic               rd_msb,
  input  logic               rd_lsb,
  output logic [PH_W-1:0]    phase_code,
  output logic [VO_W-1:0]    volt_code,
  output logic [7:0]         msb_byte,
  output logic [7:0]         lsb_byte,
  output logic               start_bit
);
  import eyescan_pkg::*;

  localparam int GRID = 1 << (PH_W + VO_W);
  localparam int PC_W = PH_W + VO_W + 1;

  // Named internal events, also observed by the bound checker.
  logic             start_evt;
  logic             abort;
  logic             clear;
  logic             step_evt;
  logic             pair_evt;
  logic             last_pair;
  logic             done_evt;
  logic             acc_clear;
  logic             in_grid;
  logic             dwell_full;
  logic [RES_W-1:0] err_cnt;
  logic [RES_W-1:0] capt_val;

  assign start_evt = scan_en && start_req;
  assign abort     = !scan_en;
  assign clear     = start_evt || abort;
  assign done_evt  = pair_evt && last_pair;
  assign acc_clear = clear || step_evt;
  assign capt_val  = in_grid ? err_cnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         start_bit <= 1'b0;
    else if (abort)     start_bit <= 1'b0;
    else if (start_evt) start_bit <= 1'b1;
    else if (done_evt)  start_bit <= 1'b0;
  end

  eyescan_accum #(
    .DWELL_W     (DWELL_W),
    .DWELL_SHIFT (DWELL_SHIFT)
  ) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (acc_clear),
    .active     (start_bit && in_grid),
    .smp_vld    (smp_vld),
    .prim_bit   (prim_bit),
    .offs_bit   (offs_bit),
    .dwell      (dwell),
    .err_cnt    (err_cnt),
    .dwell_full (dwell_full)
  );

  eyescan_stepper #(
    .PH_W (PH_W),
    .VO_W (VO_W)
  ) u_stepper (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .advance    (step_evt),
    .in_grid    (in_grid),
    .phase_code (phase_code),
    .volt_code  (volt_code)
  );

  eyescan_window #(
    .GRID    (GRID),
    .RES_LAG (RES_LAG),
    .PC_W    (PC_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .running   (start_bit),
    .burst     (burst_mode),
    .rd_msb    (rd_msb),
    .rd_lsb    (rd_lsb),
    .capt_val  (capt_val),
    .msb_byte  (msb_byte),
    .lsb_byte  (lsb_byte),
    .step_evt  (step_evt),
    .pair_evt  (pair_evt),
    .last_pair (last_pair)
  );

endmodule

// File: rtl/eyescan_engine_chk.sv
module eyescan_engine_chk #(
  parameter int PH_W = 6,
  parameter int VO_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_en,
  input logic            start_bit,
  input logic            start_evt,
  input logic            step_evt,
  input logic            pair_evt,
  input logic            acc_clear,
  input logic [15:0]     err_cnt,
  input logic [PH_W-1:0] phase_code,
  input logic [VO_W-1:0] volt_code,
  input logic [7:0]      msb_byte,
  input logic [7:0]      lsb_byte
);

  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !start_bit);

  p_count_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clear |=> err_cnt >= $past(err_cnt));

  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == 16'hFFFF && !acc_clear) |=> err_cnt == 16'hFFFF);

  p_codes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !start_evt && !step_evt) |=> $stable({phase_code, volt_code}));

  p_win_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !start_evt && !pair_evt) |=> $stable(lsb_byte));

  p_run_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && scan_en && !pair_evt) |=> start_bit);

  p_abort_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ({phase_code, volt_code} == '0 && msb_byte == 8'h00));

endmodule

bind eyescan_engine eyescan_engine_chk #(.PH_W(PH_W), .VO_W(VO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_en    (scan_en),
  .start_bit  (start_bit),
  .start_evt  (start_evt),
  .step_evt   (step_evt),
  .pair_evt   (pair_evt),
  .acc_clear  (acc_clear),
  .err_cnt    (err_cnt),
  .phase_code (phase_code),
  .volt_code  (volt_code),
  .msb_byte   (msb_byte),
  .lsb_byte   (lsb_byte)
);

// File: tb/eyescan_engine_tb.sv
module eyescan_engine_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_en = 1'b0;
  logic       start_req = 1'b0;
  logic       burst_mode = 1'b0;
  logic [7:0] dwell = 8'd0;
  logic       smp_vld = 1'b0;
  logic       prim_bit = 1'b0;
  logic       offs_bit = 1'b0;
  logic       rd_msb = 1'b0;
  logic       rd_lsb = 1'b0;
  logic [5:0] phase_code;
  logic [5:0] volt_code;
  logic [7:0] msb_byte;
  logic [7:0] lsb_byte;
  logic       start_bit;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  eyescan_engine #(.DWELL_SHIFT(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .start_req(start_req),
    .burst_mode(burst_mode), .dwell(dwell), .smp_vld(smp_vld),
    .prim_bit(prim_bit), .offs_bit(offs_bit), .rd_msb(rd_msb), .rd_lsb(rd_lsb),
    .phase_code(phase_code), .volt_code(volt_code), .msb_byte(msb_byte),
    .lsb_byte(lsb_byte), .start_bit(start_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic pulse_msb();
    @(negedge clk) rd_msb = 1'b1;
    @(negedge clk) rd_msb = 1'b0;
  endtask

  task automatic pulse_lsb();
    @(negedge clk) rd_lsb = 1'b1;
    @(negedge clk) rd_lsb = 1'b0;
  endtask

  task automatic feed(input int n, input int nerr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld  = 1'b1;
      prim_bit = 1'b1;
      offs_bit = (i < nerr) ? 1'b0 : 1'b1;
    end
    @(negedge clk) smp_vld = 1'b0;
  endtask

  task automatic begin_scan(input bit burst);
    @(negedge clk);
    scan_en    = 1'b1;
    burst_mode = burst;
    start_req  = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  // One full point: MSB byte then LSB byte, at the addresses the mode uses.
  task automatic read_pair(output int v);
    int hi;
    int lo;
    hi = int'(msb_byte);
    pulse_msb();
    if (burst_mode) begin
      lo = int'(msb_byte);
      pulse_msb();
    end else begin
      lo = int'(lsb_byte);
      pulse_lsb();
    end
    v = hi * 256 + lo;
  endtask

  task automatic t_reset();
    check("R1 start_bit", int'(start_bit), 0);
    check("R1 codes", int'({phase_code, volt_code}), 0);
    check("R1 bytes", int'({msb_byte, lsb_byte}), 0);
  endtask

  task automatic t_start_gate();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    check("R2 start ignored while disabled", int'(start_bit), 0);
    begin_scan(1'b0);
    check("R2 start accepted when enabled", int'(start_bit), 1);
  endtask

  task automatic t_single();
    int v;
    begin_scan(1'b0);
    dwell = 8'd9;
    feed(5, 3);
    read_pair(v);
    check("R9 first pair invalid", v, 0);
    check("R6 voltage steps after MSB read", int'(volt_code), 1);
    feed(7, 7);
    pulse_msb();
    pulse_msb();
    check("R6 repeated MSB read ignored", int'(volt_code), 2);
    pulse_lsb();
    check("R7 window loads after pair", int'(lsb_byte), 3);
    pulse_lsb();
    check("R7 stray LSB read keeps window", int'(lsb_byte), 3);
    check("R7 stray LSB read keeps point", int'(volt_code), 2);
    read_pair(v);
    check("R3 R9 point0 count", v, 3);
    read_pair(v);
    check("R3 point1 count", v, 7);
    dwell = 8'd0;
    feed(300, 300);
    read_pair(v);
    check("R3 point2 no errors", v, 0);
    read_pair(v);
    read_pair(v);
    check("R3 dwell limit 256 samples", v, 256);
  endtask

  task automatic t_burst();
    int v;
    begin_scan(1'b1);
    dwell = 8'd1;
    feed(300, 300);
    read_pair(v);
    check("R9 burst first pair invalid", v, 0);
    read_pair(v);
    check("R9 burst second pair invalid", v, 0);
    pulse_lsb();
    check("R8 LSB strobe ignored in burst", int'(msb_byte), 8'h01);
    check("R8 LSB strobe keeps point", int'(volt_code), 2);
    pulse_msb();
    check("R8 low byte at MSB address", int'(msb_byte), 8'h2C);
    pulse_msb();
    check("R8 pair finished by second MSB read", int'(volt_code), 3);
  endtask

  task automatic t_sat();
    int v;
    begin_scan(1'b0);
    dwell = 8'd255;
    feed(65546, 65546);
    read_pair(v);
    read_pair(v);
    read_pair(v);
    check("R4 count saturates", v, 16'hFFFF);
  endtask

  task automatic t_full();
    begin_scan(1'b0);
    for (int k = 0; k < 4098; k++) begin
      pulse_msb();
      if (k == 63) begin
        check("R5 phase carries", int'(phase_code), 1);
        check("R5 voltage wraps", int'(volt_code), 0);
      end
      if (k == 4094) check("R5 last point codes", int'({phase_code, volt_code}), 12'hFFF);
      if (k == 4095) check("R5 codes past grid", int'({phase_code, volt_code}), 0);
      pulse_lsb();
      if (k == 4096) check("R10 busy before last pair", int'(start_bit), 1);
    end
    check("R10 start clears after all data", int'(start_bit), 0);
    pulse_msb();
    check("R10 reads ignored after done", int'(volt_code), 0);
  endtask

  task automatic t_abort();
    begin_scan(1'b0);
    feed(10, 10);
    pulse_msb();
    check("R11 pre-abort point", int'(volt_code), 1);
    @(negedge clk) scan_en = 1'b0;
    @(negedge clk);
    check("R11 start cleared", int'(start_bit), 0);
    check("R11 codes cleared", int'({phase_code, volt_code}), 0);
    check("R11 window cleared", int'({msb_byte, lsb_byte}), 0);
    scan_en = 1'b1;
    pulse_msb();
    check("R11 idle read ignored", int'(volt_code), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_gate();
    t_single();
    t_burst();
    t_sat();
    t_full();
    t_abort();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule